// File: doc/BRIEF.md
# SYSREF Alignment Window Monitor

This block shows where the edge of a multi-chip synchronization reference (SYSREF) lands relative to the sampling clock. Outside logic captures SYSREF on six staggered delay taps around the nominal capture point, which is the sampling clock rising edge plus 60 ps. The monitor compares each pair of neighbouring taps. A pair that disagrees shows that the transition fell in the timing window between those two taps. The five windows together cover the span from 60 ps before to 140 ps after the clock edge. Window 1 covers 20–60 ps of lead. Window 2 covers ±20 ps. Windows 3, 4 and 5 cover lags of 20–60 ps, 60–100 ps and 100–140 ps. For best setup and hold margin, SYSREF should rise near the sampling clock falling edge. When that happens no window flag is raised.

The raw SYSREF level passes through a synchronizer and a rising-edge detector. The tap vector goes through a delay line of the same depth, so both paths stay aligned. On every detected rising edge, one 8-bit status register takes in three things: the five window flags, a summary flag that is the OR of those flags, and a sticky detect flag. Firmware reads the register through a small register port and clears the detect flag by writing to it.

Top module: `sysref_window_monitor`

## Requirements
- R1: After synchronous reset every status bit reads 0.
- R2: Status bit k-1 (k = 1..5) holds tap[k-1] XOR tap[k]. Here tap is the 6-bit tap vector as it was when SYSREF was first sampled high. Bit 0 is the earliest tap.
- R3: Status bit 5 equals the OR of status bits 0–4 from the same update.
- R4: Every SYSREF rising edge sets status bit 6. The bit stays set, and later edges or falling edges do not change that.
- R5: A write to address 0x140 with data bit 6 = 1 clears status bit 6. A write with data bit 6 = 0 changes nothing.
- R6: If a clearing write and an update strobe fall in the same cycle, status bit 6 ends up set.
- R7: Status bit 7 always reads 0. A read from any address other than 0x140 returns 0x00.
- R8: Between SYSREF rising edges, status bits 0–5 do not change. This holds when the taps change, while SYSREF stays high, and on SYSREF falling edges.
- R9: The status register takes its new value on the third clock rising edge, counting the edge that first samples SYSREF high. After the second edge it still shows the old value.
- R10: Taps 0–1 high and taps 2–5 low, on a rising edge, make the register read 0x62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sysref_in | input | 1 | Asynchronous SYSREF level |
| tap_in | input | 6 | SYSREF samples from the delay taps, bit 0 earliest |
| reg_addr | input | 12 | Register address for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 8 | Write data; bit 6 = 1 clears the detect flag |
| reg_rd_data | output | 8 | Read data for reg_addr (combinational) |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 12-bit address, and the status register at 0x140. With these values the three-edge update latency is short enough that a clearing write can be timed exactly onto the update strobe. That exposes the clear-versus-edge collision. Random 6-bit tap vectors, including ones that are not thermometer codes, drive every window flag pattern and the summary flag. Directed cases cover the 0x62 example and reads from other addresses.

// File: rtl/swm_pkg.sv
// Package: shared layout of the alignment status register.
// Assumes five windows, six taps and an 8-bit status word.
package swm_pkg;
    localparam int NUM_WIN   = 5;
    localparam int NUM_TAPS  = NUM_WIN + 1;
    localparam int STATUS_W  = 8;
    localparam int SUM_BIT   = NUM_WIN;
    localparam int DET_BIT   = NUM_WIN + 1;
    typedef logic [STATUS_W-1:0] status_t;
    typedef logic [NUM_WIN-1:0]  win_t;
    typedef logic [NUM_TAPS-1:0] tap_t;
endpackage

// File: rtl/swm_edge_sync.sv
// Module: synchronizes the asynchronous SYSREF level and produces a
// one-cycle strobe on each synchronized rising edge.
// Assumes STAGES >= 2 and SYSREF stays high for at least one clock.
module swm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_strobe
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // High for one cycle when the synchronized level goes from 0 to 1.
    always_comb rise_strobe = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/swm_tap_align.sv
// Module: delays the tap vector by DEPTH clocks so that it lines up
// with the synchronized SYSREF edge strobe.
// Assumes DEPTH equals the synchronizer depth and DEPTH >= 1.
module swm_tap_align #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] pipe_q [DEPTH];

    // First stage captures the raw taps.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= d_in;
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            // Later stages shift the captured taps forward.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    endgenerate

    always_comb d_out = pipe_q[DEPTH-1];
endmodule

// File: rtl/swm_window_decode.sv
// Module: XORs each pair of neighbouring taps to find the window of the
// transition, and ORs the results into a summary.
// Assumes taps are ordered earliest first; purely combinational.
module swm_window_decode
    import swm_pkg::*;
(
    input  tap_t taps,
    output win_t win,
    output logic any_win
);
    generate
        for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
            assign win[k] = taps[k] ^ taps[k+1];
        end
    endgenerate

    // Summary of all window flags.
    always_comb any_win = |win;
endmodule

// File: rtl/swm_status_reg.sv
// Module: holds the status word. Loads window and summary flags on the
// update strobe, keeps a sticky detect bit, and serves register reads.
// Assumes one status address; all other addresses read as zero.
module swm_status_reg
    import swm_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] STATUS_ADDR = 12'h140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_strobe,
    input  win_t              win,
    input  logic              any_win,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [STATUS_W-1:0] wr_data,
    output logic [STATUS_W-1:0] rd_data,
    output status_t           status
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

    win_t win_q;
    logic sum_q;
    logic det_q;
    logic addr_hit;
    logic clr_det;

    always_comb addr_hit = (addr == HIT_ADDR);
    always_comb clr_det  = wr_en & addr_hit & wr_data[DET_BIT];

    // Load window and summary flags on each SYSREF edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
            sum_q <= 1'b0;
        end else if (upd_strobe) begin
            win_q <= win;
            sum_q <= any_win;
        end
    end

    // Sticky detect bit: an edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          det_q <= 1'b0;
        else if (upd_strobe) det_q <= 1'b1;
        else if (clr_det)    det_q <= 1'b0;
    end

    // Put the status word together; the top bit is always zero.
    always_comb begin
        status          = '0;
        status[NUM_WIN-1:0] = win_q;
        status[SUM_BIT] = sum_q;
        status[DET_BIT] = det_q;
    end

    // Read mux: only the status address returns data.
    always_comb rd_data = addr_hit ? status : '0;
endmodule

// File: rtl/sysref_window_monitor.sv
// Top: SYSREF alignment window monitor. Synchronizes SYSREF, aligns the
// delay-tap samples with it, decodes the skew window and keeps a status word.
// Assumes the taps are valid in the cycle SYSREF is first sampled high.
module sysref_window_monitor
    import swm_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] STATUS_ADDR = 12'h140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_in,
    input  logic [5:0]        tap_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_data,
    output logic [7:0]        reg_rd_data
);
    logic    edge_strobe;
    tap_t    taps_aligned;
    win_t    win_flags;
    logic    win_any;
    status_t status_q;

    swm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .async_in    (sysref_in),
        .rise_strobe (edge_strobe)
    );

    swm_tap_align #(.DEPTH(SYNC_STAGES), .WIDTH(NUM_TAPS)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (tap_in),
        .d_out (taps_aligned)
    );

    swm_window_decode u_dec (
        .taps    (taps_aligned),
        .win     (win_flags),
        .any_win (win_any)
    );

    swm_status_reg #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_strobe (edge_strobe),
        .win        (win_flags),
        .any_win    (win_any),
        .addr       (reg_addr),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .rd_data    (reg_rd_data),
        .status     (status_q)
    );
endmodule

// File: rtl/swm_checker.sv
// Checker: temporal properties of the status word, bound to the top.
// Assumes the default register layout from swm_pkg.
module swm_checker #(
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] STATUS_ADDR = 12'h140
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [7:0]        status,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(STATUS_ADDR);

    // R4: an edge strobe leaves the detect bit set.
    a_r4_detect_set: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> status[6]);

    // R5: a clearing write with no edge drops the detect bit.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HIT && wr_data[6] && !strobe) |=> !status[6]);

    // R6: a clear that collides with an edge still leaves the bit set.
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && wr_en && addr == HIT && wr_data[6]) |=> status[6]);

    // R8: with no strobe the window and summary bits hold.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(status[5:0]));

    // R3: the summary bit agrees with the window bits.
    a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] == (|status[4:0]));

    // R7: the top bit is never set, and other addresses read zero.
    a_r7_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7]);
    a_r7_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != HIT) |-> (rd_data == 8'h00));
endmodule

bind sysref_window_monitor swm_checker #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (edge_strobe),
    .status  (status_q),
    .addr    (reg_addr),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .rd_data (reg_rd_data)
);

// File: tb/sysref_window_monitor_test.sv
module sysref_window_monitor_test;
    localparam logic [11:0] STAT = 12'h140;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sysref_in = 1'b0;
    logic [5:0]  tap_in = '0;
    logic [11:0] reg_addr = STAT;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic [7:0]  reg_rd_data;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_st = '0;
    int unsigned seed_v;

    always #2 clk = ~clk;   // 250 MHz

    sysref_window_monitor uut (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .tap_in(tap_in),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    function automatic logic [7:0] model_status(input logic [5:0] t);
        logic [4:0] w;
        for (int k = 0; k < 5; k++) w[k] = t[k] ^ t[k+1];
        return {1'b0, 1'b1, |w, w};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One SYSREF rising edge with the given taps; optionally collide a clear.
    task automatic sysref_event(input logic [5:0] t, input bit clr_same);
        @(negedge clk); sysref_in = 1'b1; tap_in = t; reg_addr = STAT;
        @(posedge clk);                       // edge 1: first sample
        @(negedge clk);
        @(posedge clk);                       // edge 2: strobe raised
        @(negedge clk);
        check("R9 old value after second edge", reg_rd_data, exp_st);
        if (clr_same) begin reg_wr_en = 1'b1; reg_wr_data = 8'h40; end
        @(posedge clk);                       // edge 3: status updated
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
        exp_st = model_status(t);
        check(clr_same ? "R6 edge wins over clear" : "R2/R3/R4 update", reg_rd_data, exp_st);
        // R8: taps move while SYSREF stays high, then SYSREF falls.
        for (int i = 0; i < 3; i++) begin
            tap_in = 6'($urandom());
            @(negedge clk);
        end
        sysref_in = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tap_in = 6'($urandom());
            @(negedge clk);
        end
        check("R8 hold between edges", reg_rd_data, exp_st);
    endtask

    task automatic reg_write(input logic [7:0] d);
        @(negedge clk); reg_addr = STAT; reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0;
        if (d[6]) exp_st[6] = 1'b0;
        check(d[6] ? "R5 clear detect" : "R5 write without bit 6", reg_rd_data, exp_st);
    endtask

    task automatic other_read(input logic [11:0] a);
        @(negedge clk); reg_addr = a;
        #1 check("R7 other address reads zero", reg_rd_data, 8'h00);
        @(negedge clk); reg_addr = STAT;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'h5EED_0140);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", reg_rd_data, 8'h00);

        // R10: transition between the second and third taps.
        sysref_event(6'b000011, 1'b0);
        check("R10 example 0x62", reg_rd_data, 8'h62);

        // R4: a second edge with no window flags keeps detect set.
        sysref_event(6'b000000, 1'b0);
        check("R4 no window, detect set", reg_rd_data, 8'h40);

        reg_write(8'hBF);                     // R5: bit 6 clear -> no effect
        reg_write(8'h40);                     // R5: clear
        other_read(12'h141);
        other_read(12'h000);

        sysref_event(6'b111111, 1'b1);        // R6 collision
        sysref_event(6'b011111, 1'b0);        // flag 5 only
        check("R2 window 5", reg_rd_data, 8'h70);

        for (int n = 0; n < 40; n++) begin
            logic [5:0] t;
            t = 6'($urandom());
            if ($urandom_range(0, 2) == 0) reg_write(8'h40);
            sysref_event(t, $urandom_range(0, 3) == 0);
            check("R7 bit 7 zero", {7'b0, reg_rd_data[7]}, 8'h00);
            if ($urandom_range(0, 4) == 0) other_read(12'($urandom()) | 12'h800);
        end

        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; exp_st = '0;
        @(negedge clk);
        check("R1 reset after activity", reg_rd_data, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule